// File: doc/BRIEF.md
# Byte-Serial Multicycle Processor Sequencer

This block is the control sequencer for a small multicycle processor whose datapath moves one byte at a time. A 32-bit instruction is gathered as four bytes, one per cycle, with the program counter stepping after each byte. The sequencer then spends one cycle in decode, where the ALU forms a speculative branch target. After decode it runs the steps for one of six instruction classes and returns to the start of fetch.

It is a Moore machine: every control output depends only on the current state. The only inputs are the reset and the 6-bit opcode field of the assembled instruction word. Register-to-register arithmetic, add-immediate, byte load, byte store, branch-if-equal and jump take between six and eight cycles each. ALU function decoding, the datapath and memory lie outside this block.

Top module: `mc_seq_ctrl`

## Requirements
- R1: An active-low asynchronous reset puts the block straight into the first fetch state. While reset is held, the outputs show that state's control word.
- R2: Fetch runs through four states in a fixed order, and these states ignore the opcode. Each fetch state drives mem_rd_o=1, pc_wr_o=1, addr_sel_o=0, alu_a_sel_o=0, alu_b_sel_o=01, alu_op_o=00 and pc_src_o=00. ir_wr_o is 0001, 0010, 0100 and 1000 in the four states, in that order.
- R3: The fetch states are followed by one decode state, which drives alu_a_sel_o=0, alu_b_sel_o=11 and alu_op_o=00.
- R4: Opcode 000000 (register arithmetic) runs an execute state and then a completion state. Execute drives alu_a_sel_o=1, alu_b_sel_o=00 and alu_op_o=10. Completion drives rf_wr_o=1, dst_sel_o=1 and wb_sel_o=0. The instruction takes 7 cycles.
- R5: Opcode 100000 (load byte) runs three states after decode. The address state drives alu_a_sel_o=1, alu_b_sel_o=10 and alu_op_o=00. The read state drives mem_rd_o=1 and addr_sel_o=1. The write-back state drives rf_wr_o=1, dst_sel_o=0 and wb_sel_o=1. The instruction takes 8 cycles.
- R6: Opcode 101000 (store byte) runs the same address state as R5, then a write state that drives mem_wr_o=1 and addr_sel_o=1. The instruction takes 7 cycles.
- R7: Opcode 000100 (branch-if-equal) runs one state after decode. That state drives alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=01, pc_wr_cond_o=1 and pc_src_o=01. The instruction takes 6 cycles.
- R8: Opcode 000010 (jump) runs one state after decode, which drives pc_wr_o=1 and pc_src_o=10. The instruction takes 6 cycles.
- R9: Opcode 001000 (add-immediate) runs an execute state and then a write-back state. Execute drives alu_a_sel_o=1, alu_b_sel_o=10 and alu_op_o=00. Write-back drives rf_wr_o=1, dst_sel_o=0 and wb_sel_o=0. The instruction takes 7 cycles.
- R10: Any other opcode seen in decode sends the block back to the first fetch state on the next cycle.
- R11: Every final step of an instruction returns to the first fetch state. In every state, each output not named for that state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the assembled instruction |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_sel_o | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| ir_wr_o | output | 4 | Per-byte load enables of the instruction register |
| alu_a_sel_o | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel_o | output | 2 | ALU B operand: 00 = register B, 01 = one, 10 = immediate, 11 = branch offset |
| alu_op_o | output | 2 | ALU operation class: 00 = add, 01 = subtract, 10 = by function field |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when the operands compare equal |
| pc_src_o | output | 2 | PC source: 00 = ALU, 01 = ALU result register, 10 = jump target |
| dst_sel_o | output | 1 | Destination register field: 0 = rt, 1 = rd |
| wb_sel_o | output | 1 | Write-back data: 0 = ALU result, 1 = memory data |
| rf_wr_o | output | 1 | Register file write enable |

## Verification
A wrong state shows up as a wrong control word in the very cycle the block enters it. Examples are a skipped or repeated byte enable, a strobe that should be idle, or the wrong operand select. The bench compares all 19 output bits on every cycle of every instruction class. A wrong transition also changes the cycle count of the instruction. That shows within one cycle as a missing fetch control word where the first fetch state was expected, or as a fetch word arriving early.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int unsigned OpW = 6;
  localparam int unsigned IrBytes = 4;
  localparam int unsigned StW = 4;

  localparam logic [OpW-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OpW-1:0] OP_LB    = 6'b100000;
  localparam logic [OpW-1:0] OP_SB    = 6'b101000;
  localparam logic [OpW-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OpW-1:0] OP_J     = 6'b000010;
  localparam logic [OpW-1:0] OP_ADDI  = 6'b001000;

  typedef enum logic [StW-1:0] {
    S_FETCH0, S_FETCH1, S_FETCH2, S_FETCH3,
    S_DECODE, S_MADDR, S_LD_RD, S_LD_WB, S_ST_WR,
    S_R_EXEC, S_R_WB, S_BRANCH, S_JUMP, S_I_EXEC, S_I_WB
  } state_e;

  typedef struct packed {
    logic               mem_rd;
    logic               mem_wr;
    logic               addr_sel;
    logic [IrBytes-1:0] ir_wr;
    logic               alu_a_sel;
    logic [1:0]         alu_b_sel;
    logic [1:0]         alu_op;
    logic               pc_wr;
    logic               pc_wr_cond;
    logic [1:0]         pc_src;
    logic               dst_sel;
    logic               wb_sel;
    logic               rf_wr;
  } ctrl_t;
endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e         state_i,
  input  logic [OpW-1:0] opcode_i,
  output state_e         state_o
);
  always_comb begin
    state_o = S_FETCH0;
    unique case (state_i)
      S_FETCH0: state_o = S_FETCH1;
      S_FETCH1: state_o = S_FETCH2;
      S_FETCH2: state_o = S_FETCH3;
      S_FETCH3: state_o = S_DECODE;
      S_DECODE: begin
        unique case (opcode_i)
          OP_LB, OP_SB: state_o = S_MADDR;
          OP_RTYPE:     state_o = S_R_EXEC;
          OP_BEQ:       state_o = S_BRANCH;
          OP_J:         state_o = S_JUMP;
          OP_ADDI:      state_o = S_I_EXEC;
          default:      state_o = S_FETCH0;
        endcase
      end
      S_MADDR:  state_o = (opcode_i == OP_LB) ? S_LD_RD :
                          (opcode_i == OP_SB) ? S_ST_WR : S_FETCH0;
      S_LD_RD:  state_o = S_LD_WB;
      S_R_EXEC: state_o = S_R_WB;
      S_I_EXEC: state_o = S_I_WB;
      default:  state_o = S_FETCH0;
    endcase
  end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  state_e state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      S_FETCH0, S_FETCH1, S_FETCH2, S_FETCH3: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.alu_b_sel = 2'b01;
        // byte lane follows fetch index
        ctrl_o.ir_wr     = IrBytes'(1) << (state_i - S_FETCH0);
      end
      S_DECODE: ctrl_o.alu_b_sel = 2'b11;
      S_MADDR, S_I_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = 2'b10;
      end
      S_LD_RD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_LD_WB: begin
        ctrl_o.rf_wr  = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      S_ST_WR: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_R_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_op    = 2'b10;
      end
      S_R_WB: begin
        ctrl_o.rf_wr   = 1'b1;
        ctrl_o.dst_sel = 1'b1;
      end
      S_BRANCH: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_op     = 2'b01;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = 2'b01;
      end
      S_JUMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = 2'b10;
      end
      S_I_WB: ctrl_o.rf_wr = 1'b1;
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OpW-1:0]      opcode_i,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic                addr_sel_o,
  output logic [IrBytes-1:0]  ir_wr_o,
  output logic                alu_a_sel_o,
  output logic [1:0]          alu_b_sel_o,
  output logic [1:0]          alu_op_o,
  output logic                pc_wr_o,
  output logic                pc_wr_cond_o,
  output logic [1:0]          pc_src_o,
  output logic                dst_sel_o,
  output logic                wb_sel_o,
  output logic                rf_wr_o
);
  state_e state_q, state_d;
  ctrl_t  ctrl;

  mc_next_state u_nxt (
    .state_i  (state_q),
    .opcode_i (opcode_i),
    .state_o  (state_d)
  );

  mc_out_decode u_dec (
    .state_i (state_q),
    .ctrl_o  (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH0;
    else         state_q <= state_d;
  end

  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign addr_sel_o   = ctrl.addr_sel;
  assign ir_wr_o      = ctrl.ir_wr;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign pc_src_o     = ctrl.pc_src;
  assign dst_sel_o    = ctrl.dst_sel;
  assign wb_sel_o     = ctrl.wb_sel;
  assign rf_wr_o      = ctrl.rf_wr;
endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       addr_sel_o,
  input logic [3:0] ir_wr_o,
  input logic       alu_a_sel_o,
  input logic [1:0] alu_b_sel_o,
  input logic [1:0] alu_op_o,
  input logic       pc_wr_o,
  input logic       pc_wr_cond_o,
  input logic [1:0] pc_src_o,
  input logic       dst_sel_o,
  input logic       wb_sel_o,
  input logic       rf_wr_o
);
  a_r2_ir_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ir_wr_o));
  a_r2_byte0_to_1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o[0] |=> ir_wr_o[1]);
  a_r2_byte1_to_2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o[1] |=> ir_wr_o[2]);
  a_r2_byte2_to_3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o[2] |=> ir_wr_o[3]);
  a_r3_decode_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o[3] |=> (alu_b_sel_o == 2'b11 && !mem_rd_o));
  a_r2_fetch_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_wr_o != 4'b0) |-> (mem_rd_o && pc_wr_o && !addr_sel_o));
  a_r11_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  a_r5_load_then_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && addr_sel_o) |=> (rf_wr_o && wb_sel_o && !dst_sel_o));
  a_r4_rwb_after_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_wr_o && dst_sel_o) |-> ($past(alu_op_o) == 2'b10));
  a_r6_store_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (ir_wr_o == 4'b0001));
  a_r7_branch_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |=> (ir_wr_o == 4'b0001));
  a_r8_jump_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_o && pc_src_o == 2'b10) |=> (ir_wr_o == 4'b0001));
  a_r11_wb_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_o |=> (ir_wr_o == 4'b0001));
endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .addr_sel_o   (addr_sel_o),
  .ir_wr_o      (ir_wr_o),
  .alu_a_sel_o  (alu_a_sel_o),
  .alu_b_sel_o  (alu_b_sel_o),
  .alu_op_o     (alu_op_o),
  .pc_wr_o      (pc_wr_o),
  .pc_wr_cond_o (pc_wr_cond_o),
  .pc_src_o     (pc_src_o),
  .dst_sel_o    (dst_sel_o),
  .wb_sel_o     (wb_sel_o),
  .rf_wr_o      (rf_wr_o)
);

// File: tb/sim_mc_seq_ctrl.sv
module sim_mc_seq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'b0;
  logic       mem_rd_o, mem_wr_o, addr_sel_o, alu_a_sel_o, pc_wr_o, pc_wr_cond_o;
  logic       dst_sel_o, wb_sel_o, rf_wr_o;
  logic [3:0] ir_wr_o;
  logic [1:0] alu_b_sel_o, alu_op_o, pc_src_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  mc_seq_ctrl u0 (.*);

  // {rd,wr,addr,ir[3:0],a,b[1:0],op[1:0],pcw,pcc,src[1:0],dst,wb,rf}
  localparam logic [18:0] W_F0  = 19'b1_0_0_0001_0_01_00_1_0_00_0_0_0;
  localparam logic [18:0] W_F1  = 19'b1_0_0_0010_0_01_00_1_0_00_0_0_0;
  localparam logic [18:0] W_F2  = 19'b1_0_0_0100_0_01_00_1_0_00_0_0_0;
  localparam logic [18:0] W_F3  = 19'b1_0_0_1000_0_01_00_1_0_00_0_0_0;
  localparam logic [18:0] W_DEC = 19'b0_0_0_0000_0_11_00_0_0_00_0_0_0;
  localparam logic [18:0] W_ADR = 19'b0_0_0_0000_1_10_00_0_0_00_0_0_0;
  localparam logic [18:0] W_LRD = 19'b1_0_1_0000_0_00_00_0_0_00_0_0_0;
  localparam logic [18:0] W_LWB = 19'b0_0_0_0000_0_00_00_0_0_00_0_1_1;
  localparam logic [18:0] W_SWR = 19'b0_1_1_0000_0_00_00_0_0_00_0_0_0;
  localparam logic [18:0] W_REX = 19'b0_0_0_0000_1_00_10_0_0_00_0_0_0;
  localparam logic [18:0] W_RWB = 19'b0_0_0_0000_0_00_00_0_0_00_1_0_1;
  localparam logic [18:0] W_BR  = 19'b0_0_0_0000_1_00_01_0_1_01_0_0_0;
  localparam logic [18:0] W_JMP = 19'b0_0_0_0000_0_00_00_1_0_10_0_0_0;
  localparam logic [18:0] W_IWB = 19'b0_0_0_0000_0_00_00_0_0_00_0_0_1;

  function automatic logic [18:0] obs();
    return {mem_rd_o, mem_wr_o, addr_sel_o, ir_wr_o, alu_a_sel_o, alu_b_sel_o,
            alu_op_o, pc_wr_o, pc_wr_cond_o, pc_src_o, dst_sel_o, wb_sel_o, rf_wr_o};
  endfunction

  task automatic chk(input logic [18:0] exp, input string tag);
    n_chk++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, obs(), exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  // check a word then advance one cycle
  task automatic cs(input logic [18:0] exp, input string tag);
    chk(exp, tag);
    step();
  endtask

  task automatic fetch_dec(input string tag);
    cs(W_F0, {tag, " R2 fetch0"});
    cs(W_F1, {tag, " R2 fetch1"});
    cs(W_F2, {tag, " R2 fetch2"});
    cs(W_F3, {tag, " R2 fetch3"});
    cs(W_DEC, {tag, " R3 decode"});
  endtask

  task automatic t_reset();
    chk(W_F0, "R1 held reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_rtype();
    opcode_i = 6'b000000;
    fetch_dec("R4");
    cs(W_REX, "R4 execute");
    cs(W_RWB, "R4 completion");
    chk(W_F0, "R4 R11 return after 7");
  endtask

  task automatic t_load();
    opcode_i = 6'b100000;
    fetch_dec("R5");
    cs(W_ADR, "R5 address");
    cs(W_LRD, "R5 read");
    cs(W_LWB, "R5 writeback");
    chk(W_F0, "R5 R11 return after 8");
  endtask

  task automatic t_store();
    opcode_i = 6'b101000;
    fetch_dec("R6");
    cs(W_ADR, "R6 address");
    cs(W_SWR, "R6 write");
    chk(W_F0, "R6 R11 return after 7");
  endtask

  task automatic t_branch();
    opcode_i = 6'b000100;
    fetch_dec("R7");
    cs(W_BR, "R7 branch");
    chk(W_F0, "R7 R11 return after 6");
  endtask

  task automatic t_jump();
    opcode_i = 6'b000010;
    fetch_dec("R8");
    cs(W_JMP, "R8 jump");
    chk(W_F0, "R8 R11 return after 6");
  endtask

  task automatic t_addi();
    opcode_i = 6'b001000;
    fetch_dec("R9");
    cs(W_ADR, "R9 execute");
    cs(W_IWB, "R9 writeback");
    chk(W_F0, "R9 R11 return after 7");
  endtask

  task automatic t_bad_op();
    logic [5:0] bad [3] = '{6'b111111, 6'b000001, 6'b100011};
    foreach (bad[i]) begin
      opcode_i = bad[i];
      fetch_dec("R10");
      chk(W_F0, "R10 unknown opcode back to fetch");
    end
  endtask

  task automatic t_fetch_ignores_op();
    // opcode churns during fetch; decode sees jump
    opcode_i = 6'b100000; cs(W_F0, "R2 fetch0 op varies");
    opcode_i = 6'b111111; cs(W_F1, "R2 fetch1 op varies");
    opcode_i = 6'b000100; cs(W_F2, "R2 fetch2 op varies");
    opcode_i = 6'b000010; cs(W_F3, "R2 fetch3 op varies");
    cs(W_DEC, "R3 decode");
    cs(W_JMP, "R8 jump after churn");
    chk(W_F0, "R8 R11 return");
  endtask

  task automatic t_async_reset();
    opcode_i = 6'b100000;
    cs(W_F0, "R1 pre");
    cs(W_F1, "R1 pre");
    chk(W_F2, "R1 pre");
    rst_ni = 1'b0;
    #1;
    chk(W_F0, "R1 async reset mid fetch");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_load();
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_rtype();
    t_load();
    t_store();
    t_branch();
    t_jump();
    t_addi();
    t_bad_op();
    t_fetch_ignores_op();
    t_async_reset();
    t_store();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule